// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Unit

This unit is the interrupt section of a 16550-style serial port. It sits on the port's register bus, which has a 3-bit address, separate read and write strobes and 8-bit data. It owns three registers: the interrupt enable register, the interrupt identification register, and the OUT2 bit of the modem control register. The rest of the port, meaning the shifters, FIFOs and line logic, sends it one-cycle event pulses: receive data ready, holding register drained, line error, and modem status change. It also supplies two levels, holding-register-empty and shift-register-idle. The unit turns these into one registered interrupt request.

Each source keeps an active flag. The received-data, line-status and modem-status sources also keep a pending latch. An event that arrives while its source is disabled is held in that latch and fires when the source is enabled. The holding-register source works differently. Enabling it samples the holding-register-empty level at once, and disabling it drops its flag. The identification register reports the highest-priority active source. OUT2 gates only the external request pin and never changes what the identification register shows.

The bus is a plain register interface with no handshake. A strobe is accepted in the cycle it is high, and read data is a combinational function of the address and the current state. The unit drives only its own three registers; reads of any other address return 0 here and are merged with other read data outside the unit.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending latch, active flag and OUT2 is 0. The identification register reads 0x01, the enable register reads 0x00, the modem control register reads 0x00, and `irq_out` is 0.
- R2: Address 1 is the enable register. Write bit 0 enables received data, bit 1 enables holding-register-empty, bit 2 enables line status, and bit 3 enables modem status. A read returns these 4 bits, with bits 7:4 reading 0.
- R3: Address 2 reads the identification register. Bit 0 is 1 when no source is active and 0 otherwise. Bits 2:1 give the ID of the winning source, in priority order line status 11 > received data 10 > holding empty 01 > modem status 00. Bits 7:3 read 0, and the value never depends on OUT2.
- R4: Address 4 bit 3 is OUT2 and reads back at bit 3, with other bits 0. `irq_out` is registered and equals the OR of all active flags ANDed with OUT2, one cycle after the access or event that caused it.
- R5: A received-data, line-status or modem-status event sets that source's active flag if the source is enabled. If the source is disabled, the event sets its pending latch instead. When the enable goes from 0 to 1, the pending latch moves into the active flag and the latch clears.
- R6: Writing the enable register with the value it already holds does not set, move or clear any flag or latch.
- R7: When the holding-empty enable goes from 0 to 1, its active flag takes the current value of `thr_empty_lvl`. When the enable goes from 1 to 0, the flag clears.
- R8: A read of the identification register clears the holding-empty active flag.
- R9: A write to address 0 (transmit data) with `tsr_idle` = 1 sets the holding-empty flag if that source is enabled. With `tsr_idle` = 0, the write clears the flag.
- R10: A read of address 0 clears the received-data flag, a read of address 5 clears the line-status flag, and a read of address 6 clears the modem-status flag. If an enabled event for the same source arrives in that cycle, the event wins.
- R11: A holding-empty event sets its flag only while that source is enabled, and nothing is latched while it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for addresses 1, 2 and 4, otherwise 0 |
| ev_rx_ready | input | 1 | Pulse: a received byte is ready |
| ev_thr_empty | input | 1 | Pulse: the holding register became empty |
| ev_line_err | input | 1 | Pulse: a receiver line error occurred |
| ev_modem_chg | input | 1 | Pulse: a modem status input changed |
| thr_empty_lvl | input | 1 | Level: the holding register is empty |
| tsr_idle | input | 1 | Level: the transmit shift register is idle |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench targets a source that is enabled while its latch already holds an event, which must show in the identification register right away. A design that drops the latch would stay silent there. It then rewrites an unchanged enable value, where a design that runs the edge actions on every write would re-fire a cleared holding-empty flag. It checks OUT2 toggling with active sources, which exposes a design that masks the identification register along with the pin. Finally it checks same-cycle collisions of clear accesses, events and enable changes, which exposes a wrong priority order among the per-source updates.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned NUM_LAT = 3;

  // Enable-bit / active-flag index of each source
  localparam int unsigned SRC_RX  = 0;
  localparam int unsigned SRC_THR = 1;
  localparam int unsigned SRC_LS  = 2;
  localparam int unsigned SRC_MS  = 3;

  // Register addresses decoded by neighbouring software
  localparam int unsigned ADR_DATA  = 0;
  localparam int unsigned ADR_IEN   = 1;
  localparam int unsigned ADR_IID   = 2;
  localparam int unsigned ADR_MCTL  = 4;
  localparam int unsigned ADR_LSTAT = 5;
  localparam int unsigned ADR_MSTAT = 6;

  localparam int unsigned OUT2_BIT = 3;

  typedef enum logic [1:0] {
    ID_MS  = 2'b00,
    ID_THR = 2'b01,
    ID_RX  = 2'b10,
    ID_LS  = 2'b11
  } irq_id_e;

  // Map latched-source slot to its enable index
  function automatic int unsigned lat_src(input int unsigned slot);
    case (slot)
      0:       return SRC_RX;
      1:       return SRC_LS;
      default: return SRC_MS;
    endcase
  endfunction
endpackage

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NSRC   = NUM_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   en_new,
  output logic [NSRC-1:0]   en_rise,
  output logic              thr_fall,
  output logic              out2_q,
  output logic              out2_new,
  output logic              data_wr,
  output logic              iid_rd,
  output logic [NUM_LAT-1:0] clr_rd
);
  logic ien_wr, mctl_wr;
  logic unused_wdata;

  assign ien_wr  = wr && (addr == ADDR_W'(ADR_IEN));
  assign mctl_wr = wr && (addr == ADDR_W'(ADR_MCTL));
  assign data_wr = wr && (addr == ADDR_W'(ADR_DATA));
  assign iid_rd  = rd && (addr == ADDR_W'(ADR_IID));

  // clear strobes in latched-slot order: rx, line status, modem status
  assign clr_rd[0] = rd && (addr == ADDR_W'(ADR_DATA));
  assign clr_rd[1] = rd && (addr == ADDR_W'(ADR_LSTAT));
  assign clr_rd[2] = rd && (addr == ADDR_W'(ADR_MSTAT));

  assign en_new   = ien_wr ? wdata[NSRC-1:0] : en_q;
  assign en_rise  = en_new & ~en_q;
  assign thr_fall = en_q[SRC_THR] & ~en_new[SRC_THR];
  assign out2_new = mctl_wr ? wdata[OUT2_BIT] : out2_q;

  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      out2_q <= 1'b0;
    end else begin
      en_q   <= en_new;
      out2_q <= out2_new;
    end
  end
endmodule

// File: rtl/irq_latched_src.sv
module irq_latched_src (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic clear_i,
  input  logic en_new_i,
  input  logic en_rise_i,
  output logic act_o,
  output logic act_nxt_o,
  output logic pend_o
);
  logic pend_nxt;

  always_comb begin
    act_nxt_o = act_o;
    pend_nxt  = pend_o;
    if (clear_i)              act_nxt_o = 1'b0;
    if (event_i && en_new_i)  act_nxt_o = 1'b1;
    if (event_i && !en_new_i) pend_nxt  = 1'b1;
    if (en_rise_i) begin
      act_nxt_o = act_nxt_o | pend_nxt;
      pend_nxt  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_o  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      act_o  <= act_nxt_o;
      pend_o <= pend_nxt;
    end
  end
endmodule

// File: rtl/irq_thr_src.sv
module irq_thr_src (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic iid_rd_i,
  input  logic data_wr_i,
  input  logic tsr_idle_i,
  input  logic lvl_i,
  input  logic en_new_i,
  input  logic en_rise_i,
  input  logic en_fall_i,
  output logic act_o,
  output logic act_nxt_o
);
  always_comb begin
    act_nxt_o = act_o;
    if (iid_rd_i)             act_nxt_o = 1'b0;
    if (data_wr_i)            act_nxt_o = tsr_idle_i & en_new_i;
    if (event_i && en_new_i)  act_nxt_o = 1'b1;
    if (en_rise_i)            act_nxt_o = lvl_i;
    if (en_fall_i)            act_nxt_o = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_o <= 1'b0;
    else        act_o <= act_nxt_o;
  end
endmodule

// File: rtl/irq_prio_id.sv
module irq_prio_id
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NSRC   = NUM_SRC
) (
  input  logic [NSRC-1:0]   act_i,
  output logic [DATA_W-1:0] iid_o
);
  irq_id_e id;

  always_comb begin
    if (act_i[SRC_LS])       id = ID_LS;
    else if (act_i[SRC_RX])  id = ID_RX;
    else if (act_i[SRC_THR]) id = ID_THR;
    else                     id = ID_MS;
    iid_o      = '0;
    iid_o[0]   = ~|act_i;
    iid_o[2:1] = id;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_rx_ready,
  input  logic              ev_thr_empty,
  input  logic              ev_line_err,
  input  logic              ev_modem_chg,
  input  logic              thr_empty_lvl,
  input  logic              tsr_idle,
  output logic              irq_out
);
  logic [NUM_SRC-1:0] en_q, en_new, en_rise;
  logic [NUM_SRC-1:0] act_all, act_nxt;
  logic [NUM_LAT-1:0] pend_all, clr_rd, ev_lat;
  logic               thr_fall, out2_q, out2_new, data_wr, iid_rd;
  logic [DATA_W-1:0]  iid;
  logic               irq_q;

  irq_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NUM_SRC)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .en_q(en_q), .en_new(en_new), .en_rise(en_rise),
    .thr_fall(thr_fall), .out2_q(out2_q), .out2_new(out2_new),
    .data_wr(data_wr), .iid_rd(iid_rd), .clr_rd(clr_rd)
  );

  assign ev_lat = {ev_modem_chg, ev_line_err, ev_rx_ready};

  for (genvar g = 0; g < NUM_LAT; g++) begin : g_lat
    localparam int unsigned S = lat_src(g);
    irq_latched_src src_i (
      .clk(clk), .rst_n(rst_n), .event_i(ev_lat[g]), .clear_i(clr_rd[g]),
      .en_new_i(en_new[S]), .en_rise_i(en_rise[S]),
      .act_o(act_all[S]), .act_nxt_o(act_nxt[S]), .pend_o(pend_all[g])
    );
  end

  irq_thr_src thr_i (
    .clk(clk), .rst_n(rst_n), .event_i(ev_thr_empty), .iid_rd_i(iid_rd),
    .data_wr_i(data_wr), .tsr_idle_i(tsr_idle), .lvl_i(thr_empty_lvl),
    .en_new_i(en_new[SRC_THR]), .en_rise_i(en_rise[SRC_THR]),
    .en_fall_i(thr_fall), .act_o(act_all[SRC_THR]),
    .act_nxt_o(act_nxt[SRC_THR])
  );

  irq_prio_id #(.DATA_W(DATA_W), .NSRC(NUM_SRC)) prio_i (
    .act_i(act_all), .iid_o(iid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (|act_nxt) & out2_new;
  end
  assign irq_out = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_IEN))       bus_rdata = DATA_W'(en_q);
    else if (bus_addr == ADDR_W'(ADR_IID))  bus_rdata = iid;
    else if (bus_addr == ADDR_W'(ADR_MCTL)) bus_rdata[OUT2_BIT] = out2_q;
  end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic       ev_rx_ready,
  input logic       ev_thr_empty,
  input logic       ev_line_err,
  input logic       ev_modem_chg,
  input logic       thr_empty_lvl,
  input logic [3:0] en_q,
  input logic [3:0] act_all,
  input logic [2:0] pend_all,
  input logic       out2_q,
  input logic       irq_out
);
  logic ien_wr, quiet;
  assign ien_wr = bus_wr && (bus_addr == 3'(ADR_IEN));
  assign quiet  = !bus_rd && !ev_rx_ready && !ev_thr_empty && !ev_line_err && !ev_modem_chg;

  assert_out2_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> out2_q);

  assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((|act_all) && out2_q));

  assert_thr_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && bus_wdata[SRC_THR] && !en_q[SRC_THR]) |=> (act_all[SRC_THR] == $past(thr_empty_lvl)));

  assert_same_ien_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && (bus_wdata[3:0] == en_q) && quiet) |=> ($stable(act_all) && $stable(pend_all)));

  assert_rx_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_ready && !en_q[SRC_RX] && !ien_wr) |=> pend_all[0]);

  assert_iid_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 3'(ADR_IID)) && !bus_wr && !ev_thr_empty) |=> !act_all[SRC_THR]);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .ev_rx_ready(ev_rx_ready),
  .ev_thr_empty(ev_thr_empty), .ev_line_err(ev_line_err),
  .ev_modem_chg(ev_modem_chg), .thr_empty_lvl(thr_empty_lvl),
  .en_q(en_q), .act_all(act_all), .pend_all(pend_all),
  .out2_q(out2_q), .irq_out(irq_out)
);

// File: tb/uart_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ev_rx_ready = 0, ev_thr_empty = 0, ev_line_err = 0, ev_modem_chg = 0;
  logic       thr_empty_lvl = 0, tsr_idle = 0;
  logic       irq_out;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model: index 0 rx, 1 thr, 2 line status, 3 modem status
  logic [3:0] m_ier, m_act, m_pend;
  logic       m_out2;

  always #4 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_ready(ev_rx_ready), .ev_thr_empty(ev_thr_empty),
    .ev_line_err(ev_line_err), .ev_modem_chg(ev_modem_chg),
    .thr_empty_lvl(thr_empty_lvl), .tsr_idle(tsr_idle), .irq_out(irq_out)
  );

  function automatic logic [7:0] f_iid(input logic [3:0] a);
    if (a[2])      return 8'h06;
    else if (a[0]) return 8'h04;
    else if (a[1]) return 8'h02;
    else if (a[3]) return 8'h00;
    else           return 8'h01;
  endfunction

  function automatic logic [7:0] f_read(input logic [2:0] a);
    case (a)
      3'd1:    return {4'b0, m_ier};
      3'd2:    return f_iid(m_act);
      3'd4:    return {4'b0, m_out2, 3'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit wr, input bit rd,
                      input logic [2:0] a, input logic [7:0] d,
                      input logic [3:0] ev, input bit lvl, input bit tsr);
    logic [3:0] ne, rise;
    logic       na, np, c;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    ev_rx_ready = ev[0]; ev_thr_empty = ev[1]; ev_line_err = ev[2]; ev_modem_chg = ev[3];
    thr_empty_lvl = lvl; tsr_idle = tsr;
    #1;
    if (rd && (a == 3'd1 || a == 3'd2 || a == 3'd4))
      check({tag, " rdata"}, bus_rdata, f_read(a));
    ne   = (wr && a == 3'd1) ? d[3:0] : m_ier;
    rise = ne & ~m_ier;
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      c  = rd && (a == ((s == 0) ? 3'd0 : (s == 2) ? 3'd5 : 3'd6));
      na = m_act[s];
      if (c) na = 1'b0;
      if (ev[s] && ne[s]) na = 1'b1;
      np = m_pend[s] | (ev[s] & ~ne[s]);
      if (rise[s]) begin na = na | np; np = 1'b0; end
      m_act[s] = na; m_pend[s] = np;
    end
    na = m_act[1];
    if (rd && a == 3'd2) na = 1'b0;
    if (wr && a == 3'd0) na = tsr & ne[1];
    if (ev[1] && ne[1]) na = 1'b1;
    if (rise[1]) na = lvl;
    if (m_ier[1] && !ne[1]) na = 1'b0;
    m_act[1] = na;
    m_ier = ne;
    if (wr && a == 3'd4) m_out2 = d[3];
    @(posedge clk);
    #1;
    check({tag, " irq"}, {7'b0, irq_out}, {7'b0, (|m_act) & m_out2});
    bus_wr = 0; bus_rd = 0;
    ev_rx_ready = 0; ev_thr_empty = 0; ev_line_err = 0; ev_modem_chg = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a);
    step(tag, 0, 1, a, 8'h00, 4'b0, thr_empty_lvl, tsr_idle);
  endtask

  task automatic wr_reg(input string tag, input logic [2:0] a, input logic [7:0] d, input bit lvl, input bit tsr);
    step(tag, 1, 0, a, d, 4'b0, lvl, tsr);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_ier = '0; m_act = '0; m_pend = '0; m_out2 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 iid after reset", 3'd2);
    rd_chk("R1 ien after reset", 3'd1);
    rd_chk("R1 mctl after reset", 3'd4);

    // R5 event while disabled is latched, not active
    step("R5 rx event disabled", 0, 0, 3'd7, 8'h00, 4'b0001, 0, 0);
    rd_chk("R5 iid idle while latched", 3'd2);
    wr_reg("R5 enable rx", 3'd1, 8'h01, 0, 0);
    rd_chk("R5 latched rx fires", 3'd2);

    // R4 OUT2 gates only the pin
    wr_reg("R4 set out2", 3'd4, 8'h08, 0, 0);
    rd_chk("R4 mctl readback", 3'd4);
    wr_reg("R4 clear out2", 3'd4, 8'h00, 0, 0);
    rd_chk("R4 iid independent of out2", 3'd2);
    wr_reg("R4 set out2 again", 3'd4, 8'h08, 0, 0);

    // R6 same-value rewrite
    wr_reg("R6 rewrite ien", 3'd1, 8'h01, 0, 0);
    rd_chk("R6 iid unchanged", 3'd2);

    // R10 read of data register clears rx
    rd_chk("R10 rx clear", 3'd0);
    rd_chk("R10 iid after rx clear", 3'd2);

    // R7 thr enable samples level
    wr_reg("R7 enable thr lvl1", 3'd1, 8'h03, 1, 0);
    rd_chk("R8 iid shows thr then clears", 3'd2);
    rd_chk("R8 iid after clear", 3'd2);

    // R9 transmit write
    wr_reg("R9 write tsr idle", 3'd0, 8'hA5, 1, 1);
    rd_chk("R9 thr re-asserted", 3'd1);
    step("R9 thr visible", 0, 0, 3'd7, 8'h00, 4'b0, 1, 0);
    wr_reg("R9 write tsr busy", 3'd0, 8'h5A, 0, 0);
    step("R9 thr cleared", 0, 1, 3'd2, 8'h00, 4'b0, 0, 0);

    // R3 priority: line status over rx
    step("R5 ls event disabled", 0, 0, 3'd7, 8'h00, 4'b0100, 0, 0);
    step("R3 rx event enabled", 0, 0, 3'd7, 8'h00, 4'b0001, 0, 0);
    wr_reg("R5 enable ls", 3'd1, 8'h07, 0, 0);
    rd_chk("R3 ls wins over rx", 3'd2);
    step("R10 ls clear with rx event collide", 0, 1, 3'd5, 8'h00, 4'b0001, 0, 0);
    rd_chk("R3 rx after ls clear", 3'd2);
    step("R10 rx clear loses to event", 0, 1, 3'd0, 8'h00, 4'b0001, 0, 0);
    rd_chk("R10 rx still active", 3'd2);
    rd_chk("R10 rx clear", 3'd0);

    // R7 fall and R11 no latch for thr
    wr_reg("R7 disable thr", 3'd1, 8'h05, 1, 0);
    step("R11 thr event disabled", 0, 0, 3'd7, 8'h00, 4'b0010, 0, 0);
    wr_reg("R11 enable thr lvl0", 3'd1, 8'h07, 0, 0);
    rd_chk("R11 no thr latched", 3'd2);
    step("R11 thr event enabled", 0, 0, 3'd7, 8'h00, 4'b0010, 1, 0);
    rd_chk("R11 thr active", 3'd2);

    // R2 upper enable bits
    wr_reg("R2 write ff", 3'd1, 8'hFF, 0, 0);
    rd_chk("R2 ien readback", 3'd1);
    step("R3 modem event", 0, 0, 3'd7, 8'h00, 4'b1000, 0, 0);
    wr_reg("R2 write 08", 3'd1, 8'h08, 0, 0);
    rd_chk("R3 modem id", 3'd2);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      bit wr, rd;
      case ($urandom_range(0, 7))
        0: a = 3'd0; 1: a = 3'd1; 2: a = 3'd1; 3: a = 3'd2;
        4: a = 3'd4; 5: a = 3'd5; 6: a = 3'd6; default: a = 3'd3;
      endcase
      d  = 8'($urandom);
      wr = ($urandom_range(0, 9) < 3);
      rd = ($urandom_range(0, 9) < 4);
      step("R5/R7/R9 random", wr, rd, a, d,
           {($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
            ($urandom_range(0, 9) == 0), ($urandom_range(0, 5) == 0)},
           1'($urandom), 1'($urandom));
    end

    done = 1;
    finish_run();
  end
endmodule